// File: doc/BRIEF.md
# Eight-Lane Frame Serializer with Test Patterns

This block turns one parallel sample word per channel into a one-bit serial lane per channel. It runs on an internal shift clock at twelve times the frame rate, qualified by a step enable. On every twelfth enabled step it loads a fresh word into each lane and then shifts out one bit per step. Two further lanes, driven by the same load-and-shift logic, carry a frame clock at the word rate and a bit clock at six times the word rate. Because all of them come from one shifting path, receivers can align to the data using these clocks.

On any word, the data can be replaced by a built-in test pattern. The choices are an alternating deskew word, a half-zeros/half-ones sync word, or a custom word from configuration. Words can go out least-significant bit first (the default) or most-significant bit first, and test patterns are reversed under the same rule as live data. A channel marked as powered down sends a constant zero, while the clock lanes keep running. Configuration and samples are captured only at a word boundary, so a lane never carries a mixed word.

Top module: `frame_serializer`

## Requirements
- R1: A new word is loaded on every twelfth enabled step. The first enabled step after reset is a load, and each lane then presents the loaded word's 12 bits on 12 consecutive enabled steps.
- R2: With `msb_first_i`=0, word bit k is on the lane during the k-th enabled step of the word (k=0 first).
- R3: With `msb_first_i`=1, word bit 11-k is on the lane during the k-th enabled step (bit 11 first).
- R4: `pat_sel_i` encoding: 0 sends the channel's sample, 1 sends deskew word 12'hAAA, 2 sends sync word 12'h03F, 3 sends `custom_i`. The sample of channel c is `sample_i[12c+11:12c]`.
- R5: Each of the three test patterns is reversed by `msb_first_i`=1 in the same way as live data.
- R6: `frame_clk_o` is 1 during steps 0 to 5 of each word and 0 during steps 6 to 11, regardless of bit order. Its rising edge therefore coincides with a word's first bit.
- R7: `bit_clk_o` is 1 during even steps and 0 during odd steps, so it toggles on every enabled step.
- R8: If `pwr_dn_i[c]`=1 at a load, lane c is 0 for that whole word. The frame and bit clock lanes are unaffected.
- R9: `sample_i`, `pat_sel_i`, `custom_i`, `msb_first_i` and `pwr_dn_i` are used only at the load step. Changing them within a word does not alter that word.
- R10: With `step_i`=0, every output and the position within the word hold their values.
- R11: While `rst_ni`=0, all lanes, `frame_clk_o` and `bit_clk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal shift clock (12x frame rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Shift enable; one output bit per enabled cycle |
| sample_i | input | 96 | Eight 12-bit sample words, channel 0 in the low bits |
| pat_sel_i | input | 2 | Source select: live, deskew, sync, custom |
| custom_i | input | 12 | Custom pattern word |
| msb_first_i | input | 1 | 0: LSB first, 1: MSB first |
| pwr_dn_i | input | 8 | Per-channel lane blanking |
| lane_o | output | 8 | Serial data lanes |
| frame_clk_o | output | 1 | Word-rate clock lane |
| bit_clk_o | output | 1 | 6x bit clock lane |

## Verification
Every lane and both clock lanes are registered. The bit for step k of a word therefore appears just after the k-th enabled clock edge counted from the load edge, and the load edge itself puts bit 0 on the pins. The bench drives inputs and samples outputs one nanosecond after each rising edge, and builds each received word from 12 consecutive samples. Stalls are checked on the sample that follows each disabled edge. Mid-word configuration changes are made after the fifth bit. The word they disturb must still match the configuration captured at its load edge, and the next word must reflect the new configuration.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    PAT_LIVE   = 2'd0,
    PAT_DESKEW = 2'd1,
    PAT_SYNC   = 2'd2,
    PAT_CUSTOM = 2'd3
  } pat_sel_e;
endpackage

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
  parameter int WORD_W = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic load_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] pos_q;

  // reset parks on the last bit so the first step loads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= LAST;
    else if (step_i) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  assign load_o = step_i && (pos_q == LAST);

  // R1
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && pos_q == LAST) |=> (pos_q == '0));
  // R10
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q));
endmodule

// File: rtl/ser_word_sel.sv
module ser_word_sel
  import ser_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic [WORD_W-1:0] sample_i,
  input  pat_sel_e          sel_i,
  input  logic [WORD_W-1:0] custom_i,
  input  logic              msb_first_i,
  input  logic              blank_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] deskew_w, sync_w, raw_w, rev_w;

  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      deskew_w[i] = (i % 2) == 1;
      sync_w[i]   = i < (WORD_W / 2);
    end
  end

  always_comb begin
    unique case (sel_i)
      PAT_DESKEW: raw_w = deskew_w;
      PAT_SYNC:   raw_w = sync_w;
      PAT_CUSTOM: raw_w = custom_i;
      default:    raw_w = sample_i;
    endcase
  end

  always_comb begin
    for (int i = 0; i < WORD_W; i++) rev_w[i] = raw_w[WORD_W-1-i];
  end

  assign word_o = blank_i ? '0 : (msb_first_i ? rev_w : raw_w);
endmodule

// File: rtl/ser_lane_shift.sv
module ser_lane_shift #(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              serial_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= word_i;
    else if (step_i)  sr_q <= {1'b0, sr_q[WORD_W-1:1]};
  end

  assign serial_o = sr_q[0];

  // R10
  sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(sr_q));
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import ser_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic [NUM_CH*WORD_W-1:0] sample_i,
  input  logic [1:0]               pat_sel_i,
  input  logic [WORD_W-1:0]        custom_i,
  input  logic                     msb_first_i,
  input  logic [NUM_CH-1:0]        pwr_dn_i,
  output logic [NUM_CH-1:0]        lane_o,
  output logic                     frame_clk_o,
  output logic                     bit_clk_o
);
  localparam int HALF_W = WORD_W / 2;

  logic load;
  logic [WORD_W-1:0] frame_word, bitclk_word;
  pat_sel_e sel;

  assign sel = pat_sel_e'(pat_sel_i);

  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      frame_word[i]  = i < HALF_W;
      bitclk_word[i] = (i % 2) == 0;
    end
  end

  ser_bit_timer #(.WORD_W(WORD_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step_i),
    .load_o(load)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [WORD_W-1:0] word;

    ser_word_sel #(.WORD_W(WORD_W)) u_sel (
      .sample_i   (sample_i[c*WORD_W +: WORD_W]),
      .sel_i      (sel),
      .custom_i   (custom_i),
      .msb_first_i(msb_first_i),
      .blank_i    (pwr_dn_i[c]),
      .word_o     (word)
    );

    ser_lane_shift #(.WORD_W(WORD_W)) u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step_i),
      .load_i  (load),
      .word_i  (word),
      .serial_o(lane_o[c])
    );

    // R8
    blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load && pwr_dn_i[c]) |=> !lane_o[c]);
  end

  // clock lanes share the data shift path
  ser_lane_shift #(.WORD_W(WORD_W)) u_frame_lane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_i),
    .load_i  (load),
    .word_i  (frame_word),
    .serial_o(frame_clk_o)
  );

  ser_lane_shift #(.WORD_W(WORD_W)) u_bitclk_lane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_i),
    .load_i  (load),
    .word_i  (bitclk_word),
    .serial_o(bit_clk_o)
  );

  // R6
  frame_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_clk_o) |-> $past(load));
  // R7
  bitclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (bit_clk_o != $past(bit_clk_o)));
endmodule

// File: tb/tb_frame_serializer.sv
module tb_frame_serializer;
  localparam int NUM_CH = 8;
  localparam int WORD_W = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic step_i = 1'b0;
  logic [NUM_CH*WORD_W-1:0] sample_i = '0;
  logic [1:0] pat_sel_i = '0;
  logic [WORD_W-1:0] custom_i = '0;
  logic msb_first_i = 1'b0;
  logic [NUM_CH-1:0] pwr_dn_i = '0;
  logic [NUM_CH-1:0] lane_o;
  logic frame_clk_o, bit_clk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  frame_serializer #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .sample_i(sample_i),
    .pat_sel_i(pat_sel_i), .custom_i(custom_i), .msb_first_i(msb_first_i),
    .pwr_dn_i(pwr_dn_i), .lane_o(lane_o), .frame_clk_o(frame_clk_o),
    .bit_clk_o(bit_clk_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] smp(input int f, input int ch);
    return WORD_W'((f * 32'h9E3 + ch * 32'h15B + 7) & 32'hFFF);
  endfunction

  function automatic logic [WORD_W-1:0] rev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] exp_word(input int ch);
    logic [WORD_W-1:0] w;
    case (pat_sel_i)
      2'd1:    w = 12'hAAA;
      2'd2:    w = 12'h03F;
      2'd3:    w = custom_i;
      default: w = sample_i[ch*WORD_W +: WORD_W];
    endcase
    if (pwr_dn_i[ch]) return '0;
    return msb_first_i ? rev(w) : w;
  endfunction

  task automatic apply_cfg(input int i);
    pat_sel_i   = 2'(i % 4);
    msb_first_i = ((i / 4) % 2) == 1;
    pwr_dn_i    = (i >= 8) ? NUM_CH'((8'h01 << (i % 8)) | 8'hA0) : '0;
    custom_i    = WORD_W'((i * 32'h1F3 + 32'h5) & 32'hFFF);
    for (int c = 0; c < NUM_CH; c++) sample_i[c*WORD_W +: WORD_W] = smp(i, c);
  endtask

  task automatic run_frame(input int i, input bit stall, input bit chg, input string force_tag);
    logic [WORD_W-1:0] exp_l [NUM_CH];
    logic [WORD_W-1:0] got_l [NUM_CH];
    logic [WORD_W-1:0] got_f, got_b;
    logic [1:0] sel0;
    logic msb0;
    logic [NUM_CH-1:0] pd0;
    string tag;
    for (int c = 0; c < NUM_CH; c++) begin
      exp_l[c] = exp_word(c);
      got_l[c] = '0;
    end
    sel0 = pat_sel_i; msb0 = msb_first_i; pd0 = pwr_dn_i;
    got_f = '0; got_b = '0;
    for (int b = 0; b < WORD_W; b++) begin
      @(posedge clk_i); #1;
      for (int c = 0; c < NUM_CH; c++) got_l[c][b] = lane_o[c];
      got_f[b] = frame_clk_o;
      got_b[b] = bit_clk_o;
      if (stall && b == 3) begin
        logic [NUM_CH+1:0] snap;
        snap = {frame_clk_o, bit_clk_o, lane_o};
        step_i = 1'b0;
        for (int s = 0; s < 2; s++) begin
          @(posedge clk_i); #1;
          // R10: outputs frozen while step is low
          chk({frame_clk_o, bit_clk_o, lane_o} == snap, "R10 stall hold",
              32'({frame_clk_o, bit_clk_o, lane_o}), 32'(snap));
        end
        step_i = 1'b1;
      end
      if (chg && b == 4) apply_cfg(i + 1);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (force_tag != "")   tag = force_tag;
      else if (chg)          tag = "R9 mid-word change ignored";
      else if (pd0[c])       tag = "R8 blanked lane";
      else if (msb0)         tag = (sel0 == 2'd0) ? "R3 msb-first data" : "R5 reversed pattern";
      else                   tag = (sel0 == 2'd0) ? "R2 lsb-first data" : "R4 pattern word";
      chk(got_l[c] == exp_l[c], tag, 32'(got_l[c]), 32'(exp_l[c]));
    end
    chk(got_f == 12'h03F, "R6 frame clock word", 32'(got_f), 32'h03F);
    chk(got_b == 12'h555, "R7 bit clock word", 32'(got_b), 32'h555);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R11: reset state
    chk({frame_clk_o, bit_clk_o, lane_o} == '0, "R11 reset outputs",
        32'({frame_clk_o, bit_clk_o, lane_o}), 0);
    rst_ni = 1'b1;
    repeat (3) begin
      @(posedge clk_i); #1;
      // R10: idle before first step
      chk({frame_clk_o, bit_clk_o, lane_o} == '0, "R10 idle hold",
          32'({frame_clk_o, bit_clk_o, lane_o}), 0);
    end
    apply_cfg(0);
    step_i = 1'b1;
    // R1: first enabled step loads the word
    run_frame(0, 1'b0, 1'b0, "R1 first word after reset");
    for (int i = 1; i < 20; i++) begin
      if (!((i - 1) % 3 == 1)) apply_cfg(i);
      run_frame(i, (i % 5) == 2, (i % 3) == 1, "");
    end
    pwr_dn_i = '1; pat_sel_i = 2'd1;
    run_frame(20, 1'b0, 1'b0, "");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule